// File: doc/BRIEF.md
# PCI Master-Abort Timeout Detector

This block follows every transaction that the bridge starts as bus master and decides whether it has to be ended with a master-abort because no target claimed it. A start strobe marks the first clock of the address phase. That clock counts as clock 1. From there the detector counts clocks in which the active-low DEVSEL input stays high. If no claim is seen by the fifth clock, the detector issues an abort to the master sequencer. On the following clock it asks for FRAME and then IRDY to be released, one after the other, and then it goes idle again.

In the abort clock the detector pulses two set strobes: one for the status bit "received master-abort" and one for the error-status bit. The master state machine and the register file own those bits. If the aborted command was a configuration read, the read data seen by the requester is forced to all ones and no machine check is raised. This lets software probe empty slots without knowing in advance which ones are fitted. Any other aborted command raises a machine-check request, unless the no-response mask input is set. Special-cycle commands are never timed and never abort.

Top module: `pci_mabort_detect`

## Requirements
- R1: After reset every output strobe (abort, FRAME and IRDY release, status set, error-status set, machine check) is low, and rd_data_o equals rd_data_i.
- R2: start_i is sampled together with cmd_i in the first address-phase clock, which counts as clock 1. If devsel_n_i is high in each of clocks 1 to 5, abort_o is high for exactly one clock, and that clock is clock 6.
- R3: If devsel_n_i is low in any of clocks 1 to 5, no abort, release, status, error-status or machine-check strobe follows for that transaction. A low devsel_n_i in clock 6 or later has no effect.
- R4: A start with the special-cycle command 4'b0001 never produces any of the abort-related strobes.
- R5: sts_mabort_set_o and esr_mabort_set_o are each high in the abort clock and only in that clock.
- R6: frame_rel_o is high in the abort clock and irdy_rel_o is high in the following clock. A start strobe in the clock after that is accepted as a new transaction.
- R7: When the aborted command is a configuration read (4'b1010), rd_data_o is 32'hFFFF_FFFF in the abort clock and mchk_req_o stays low.
- R8: When the aborted command is anything other than a configuration read and no_rsp_mask_i is low, mchk_req_o is high in the abort clock.
- R9: When no_rsp_mask_i is high in the abort clock, mchk_req_o stays low, and the status and error-status strobes still fire.
- R10: Outside a configuration-read abort clock, rd_data_o equals rd_data_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | High in the first address-phase clock of a master transaction |
| cmd_i | input | 4 | Bus command code, valid together with start_i |
| devsel_n_i | input | 1 | Active-low target claim from the bus |
| no_rsp_mask_i | input | 1 | Mask for the no-response machine check |
| rd_data_i | input | 32 | Read data from the bus |
| rd_data_o | output | 32 | Read data to the requester, forced to all ones on a configuration-read abort |
| abort_o | output | 1 | Master-abort request to the master state machine |
| frame_rel_o | output | 1 | Request to release FRAME |
| irdy_rel_o | output | 1 | Request to release IRDY, one clock after FRAME |
| sts_mabort_set_o | output | 1 | Set strobe for the received-master-abort status bit |
| esr_mabort_set_o | output | 1 | Set strobe for the no-response error-status bit |
| mchk_req_o | output | 1 | Machine-check request |

## Verification
Two decisions land in the same clock. In the abort clock the detector has to choose between overriding the read data and raising a machine check, and the mask input can veto the machine check in that same clock. The bench runs aborts of configuration reads and of other commands, each with the mask clear and with it set. It checks the data mux, the machine check and both set strobes together in that single clock. A claim in clock 5 and a claim in clock 6 are also driven back to back, to separate "claimed in time" from "timed out".

// File: rtl/pci_mabort_detect.sv
module pci_mabort_detect #(
  parameter int CMD_W = 4,
  parameter int DATA_W = 32,
  parameter int WAIT_CLKS = 5,
  parameter logic [CMD_W-1:0] CMD_SPECIAL = 4'b0001,
  parameter logic [CMD_W-1:0] CMD_CFG_RD = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              devsel_n_i,
  input  logic              no_rsp_mask_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              abort_o,
  output logic              frame_rel_o,
  output logic              irdy_rel_o,
  output logic              sts_mabort_set_o,
  output logic              esr_mabort_set_o,
  output logic              mchk_req_o
);
  localparam int CNT_W = $clog2(WAIT_CLKS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WAIT_CLKS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_ABORT, ST_IRDY} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [CMD_W-1:0] cmd_q;
  logic             claimed;
  logic             cfg_abort;

  assign claimed = ~devsel_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      cmd_q <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start_i && cmd_i != CMD_SPECIAL && !claimed) begin
            cmd_q <= cmd_i;
            cnt   <= CNT_W'(1);
            st    <= (WAIT_CLKS <= 1) ? ST_ABORT : ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (claimed)
            st <= ST_IDLE;
          else if (cnt == LAST_CNT)
            st <= ST_ABORT;
          else
            cnt <= cnt + 1'b1;
        end
        ST_ABORT: st <= ST_IRDY;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  assign abort_o          = (st == ST_ABORT);
  assign frame_rel_o      = abort_o;
  assign irdy_rel_o       = (st == ST_IRDY);
  assign sts_mabort_set_o = abort_o;
  assign esr_mabort_set_o = abort_o;
  assign cfg_abort        = abort_o && (cmd_q == CMD_CFG_RD);
  assign rd_data_o        = cfg_abort ? {DATA_W{1'b1}} : rd_data_i;
  assign mchk_req_o       = abort_o && !cfg_abort && !no_rsp_mask_i;
endmodule

module pci_mabort_detect_chk #(
  parameter int CMD_W = 4,
  parameter int DATA_W = 32,
  parameter logic [CMD_W-1:0] CMD_CFG_RD = 4'b1010
) (
  input logic              clk,
  input logic              rst_n,
  input logic              devsel_n,
  input logic              abort,
  input logic              irdy_rel,
  input logic              sts_set,
  input logic              esr_set,
  input logic              mchk,
  input logic              mask,
  input logic [CMD_W-1:0]  cmd_q,
  input logic [DATA_W-1:0] rd_data
);
  // R2
  abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n) abort |=> !abort);
  // R3
  abort_unclaimed_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(abort) |-> $past(devsel_n));
  // R5
  sts_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) sts_set |=> !sts_set && !esr_set);
  // R6
  irdy_after_abort_chk: assert property (@(posedge clk) disable iff (!rst_n) abort |=> irdy_rel);
  // R6
  irdy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n) irdy_rel |-> $past(abort));
  // R7
  cfg_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && cmd_q == CMD_CFG_RD) |-> (rd_data == {DATA_W{1'b1}}) && !mchk);
  // R9
  mchk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) mchk |-> abort && !mask);
endmodule

bind pci_mabort_detect pci_mabort_detect_chk #(
  .CMD_W(CMD_W), .DATA_W(DATA_W), .CMD_CFG_RD(CMD_CFG_RD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .devsel_n(devsel_n_i), .abort(abort_o),
  .irdy_rel(irdy_rel_o), .sts_set(sts_mabort_set_o), .esr_set(esr_mabort_set_o),
  .mchk(mchk_req_o), .mask(no_rsp_mask_i), .cmd_q(cmd_q), .rd_data(rd_data_o)
);

// File: tb/test_pci_mabort_detect.sv
module test_pci_mabort_detect;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  cmd_i = 4'h0;
  logic        devsel_n_i = 1'b1;
  logic        no_rsp_mask_i = 1'b0;
  logic [31:0] rd_data_i = 32'h0;
  logic [31:0] rd_data_o;
  logic        abort_o, frame_rel_o, irdy_rel_o;
  logic        sts_mabort_set_o, esr_mabort_set_o, mchk_req_o;

  pci_mabort_detect i_pci_mabort_detect (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i),
    .devsel_n_i(devsel_n_i), .no_rsp_mask_i(no_rsp_mask_i),
    .rd_data_i(rd_data_i), .rd_data_o(rd_data_o), .abort_o(abort_o),
    .frame_rel_o(frame_rel_o), .irdy_rel_o(irdy_rel_o),
    .sts_mabort_set_o(sts_mabort_set_o), .esr_mabort_set_o(esr_mabort_set_o),
    .mchk_req_o(mchk_req_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int cyc;
    bit mchk;
    bit ones;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   mon_on = 1'b0;
  bit   prev_ab = 1'b0;
  bit   done = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
  end

  always @(negedge clk) rd_data_i <= (cyc + 1) * 32'h9E37_79B9;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h cyc=%0d", req, what, act, expv, cyc);
    end
  endtask

  // Monitor: compares every cycle against the scoreboard queue
  always @(negedge clk) begin
    if (mon_on) begin
      bit   exp_ab;
      exp_t e;
      e = '{cyc: 0, mchk: 1'b0, ones: 1'b0};
      while (exp_q.size() > 0 && exp_q[0].cyc < cyc) begin
        void'(exp_q.pop_front());
        chk(1'b0, "R2", "missed abort", 32'd0, 32'd1);
      end
      exp_ab = (exp_q.size() > 0 && exp_q[0].cyc == cyc);
      if (exp_ab) e = exp_q.pop_front();
      chk(abort_o == exp_ab, "R2", "abort_o", 32'(abort_o), 32'(exp_ab));
      chk(sts_mabort_set_o == exp_ab, "R5", "sts_set", 32'(sts_mabort_set_o), 32'(exp_ab));
      chk(esr_mabort_set_o == exp_ab, "R5", "esr_set", 32'(esr_mabort_set_o), 32'(exp_ab));
      chk(frame_rel_o == exp_ab, "R6", "frame_rel", 32'(frame_rel_o), 32'(exp_ab));
      chk(irdy_rel_o == prev_ab, "R6", "irdy_rel", 32'(irdy_rel_o), 32'(prev_ab));
      chk(mchk_req_o == (exp_ab && e.mchk), "R8", "mchk_req", 32'(mchk_req_o), 32'(exp_ab && e.mchk));
      if (exp_ab && e.ones)
        chk(rd_data_o == 32'hFFFF_FFFF, "R7", "rd_data_o", rd_data_o, 32'hFFFF_FFFF);
      else
        chk(rd_data_o == rd_data_i, "R10", "rd_data_o", rd_data_o, rd_data_i);
      prev_ab = exp_ab;
    end
  end

  // Driver: claim = clock (1..) in which devsel_n goes low, 0 = never
  task automatic run_txn(input logic [3:0] cmd, input int claim, input bit mask, input int gap);
    int s;
    @(negedge clk);
    start_i = 1'b1;
    cmd_i = cmd;
    no_rsp_mask_i = mask;
    devsel_n_i = !(claim == 1);
    s = cyc + 1;
    if (cmd != 4'b0001 && (claim == 0 || claim > 5))
      exp_q.push_back('{cyc: s + 4, mchk: (cmd != 4'b1010) && !mask, ones: (cmd == 4'b1010)});
    for (int k = 2; k <= 7; k++) begin
      @(negedge clk);
      start_i = 1'b0;
      devsel_n_i = !(claim == k);
    end
    devsel_n_i = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!abort_o && !frame_rel_o && !irdy_rel_o && !sts_mabort_set_o &&
        !esr_mabort_set_o && !mchk_req_o, "R1", "strobes in reset", 32'd0, 32'd0);
    chk(rd_data_o == rd_data_i, "R1", "rd_data passthrough", rd_data_o, rd_data_i);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;
    run_txn(4'b0110, 0, 1'b0, 3);   // R2, R8: memory read times out, machine check
    run_txn(4'b1010, 0, 1'b0, 3);   // R7: configuration read, all ones, no machine check
    run_txn(4'b0111, 0, 1'b1, 3);   // R9: masked write abort
    run_txn(4'b1010, 0, 1'b1, 3);   // R7, R9
    run_txn(4'b0001, 0, 1'b0, 3);   // R4: special cycle never aborts
    run_txn(4'b0110, 1, 1'b0, 2);   // R3: claim in clock 1
    run_txn(4'b0111, 3, 1'b0, 2);   // R3: claim in clock 3
    run_txn(4'b1010, 5, 1'b0, 2);   // R3: claim in the last allowed clock
    run_txn(4'b1011, 6, 1'b0, 2);   // R3: claim too late, abort still happens
    // R6: back-to-back, new start in the clock after IRDY release
    run_txn(4'b0110, 0, 1'b0, 0);
    run_txn(4'b1010, 0, 1'b0, 4);
    chk(exp_q.size() == 0, "R2", "pending aborts", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule